// File: doc/BRIEF.md
# DRAM Mode Register Command Sequencer

This block sits in the command path of a DDR3-style memory controller. It writes the four DRAM mode registers and issues each write onto a registered command/address bus. A requester asks for a mode-register write by giving a register index, a field mask and new field values. The block merges the masked fields into a shadow copy of that register, so the bus always carries every field of the register. Only one request waits at a time, in a single-entry holding slot.

A write is released only while the bank status input reports every bank idle and precharged with no burst running. After a write, the block enforces three windows. The first is the gap before the next mode write. The second is the longer gap before any ordinary command. No-op and deselect still pass during that gap. The third is a gap during which clock-enable is forced high even when power-down is requested. Ordinary commands from the rest of the controller pass through the same output register. Downstream takes the command with an accept handshake.

The three windows are set by the parameters `T_MRD`, `T_MOD` and `T_PDE` (defaults 4, 12 and 12 cycles). `T_MRD` and `T_MOD` must each be at least 2. `ADDR_W` must be at least 9. Reset is synchronous and active low.

Top module: `mrs_seq`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cke` is 1 and `req_ready` is 1. The shadow registers hold 0x0420, 0x0044, 0x0008 and 0x0000 for indices 0 to 3, so a write with an all-zero mask sends exactly these values.
- R2: A waiting mode write goes onto the bus only while `banks_idle` is 1. While `banks_idle` is 0 it stays in the slot. Once `banks_idle` returns to 1, with no window open and the bus free, it is accepted in the next cycle.
- R3: Two accepted mode writes are at least `T_MRD` cycles apart. When the second is already waiting, the gap is exactly `T_MRD`.
- R4: An ordinary command (chip select low, code other than 000 and 111, for example 011) is accepted no earlier than `T_MOD` cycles after the last accepted mode write. When it is already waiting, the gap is exactly `T_MOD`.
- R5: A no-op (`cs_n`=0 with code 111) or a deselect (`cs_n`=1, any code) is not held by the `T_MOD` window. Presented in the cycle a mode write is accepted, it is accepted one cycle later.
- R6: A mode write drives `cmd_cs_n`=0 and `cmd_ras_n`=`cmd_cas_n`=`cmd_we_n`=0. The low two bits of `cmd_ba` carry the register index and the upper bits are 0. `cmd_addr` carries (shadow & ~mask) | (data & mask).
- R7: Bit 8 of register 0 clears itself: after a register-0 write is sent, the shadow copy holds that bit at 0 and keeps its other bits.
- R8: `cke` stays 1 while a mode write is on the bus and for `T_PDE` cycles after it is accepted. After that, `cke` is the inverse of `pd_req`.
- R9: `ready` is 1 exactly when `banks_idle` is 1 and none of the three windows is running.
- R10: While `cmd_valid` is 1 and `cmd_accept` is 0, the bus keeps the same command.
- R11: `req_ready` is 0 while a request waits in the slot. When a mode write and an ordinary command compete for a free bus, the mode write goes first.
- R12: Reset after writes puts every shadow register back to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode write request |
| req_idx | input | 2 | Register index |
| req_mask | input | ADDR_W | Fields to change |
| req_data | input | ADDR_W | New field values |
| req_ready | output | 1 | Holding slot empty |
| oth_valid | input | 1 | Ordinary command offered |
| oth_cs_n | input | 1 | Its chip select (1 = deselect) |
| oth_cmd | input | 3 | Its {ras_n,cas_n,we_n} code |
| oth_ba | input | BANK_W | Its bank address |
| oth_addr | input | ADDR_W | Its address |
| oth_ready | output | 1 | Ordinary command taken this cycle |
| banks_idle | input | 1 | All banks idle, precharged, no burst |
| pd_req | input | 1 | Power-down requested |
| cmd_accept | input | 1 | Downstream takes the bus command |
| cmd_valid | output | 1 | Bus command present |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ADDR_W | Address / register contents |
| cke | output | 1 | Clock enable |
| ready | output | 1 | Idle and no window running |

## Verification
There is a fixed latency from each input to its result:

- A request taken at one edge is loaded at the next edge and accepted one cycle later, when `cmd_accept` is high.
- Releasing `banks_idle` gives an accepted write one cycle later.
- A waiting second mode write lands exactly `T_MRD` cycles after the first, and a waiting ordinary command exactly `T_MOD` cycles after it. An exempt one lands one cycle after it.
- `cke` falls `T_PDE` cycles after acceptance, and `ready` rises at the later of `T_MOD`-1 and `T_PDE`.

The bench drives inputs on the falling edge. A monitor samples one time unit later and stamps every accepted command with a cycle count. The gaps are checked as exact differences of those stamps, and `cke` and `ready` are compared in every cycle of the window.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

    localparam int NUM_MR        = 4;
    localparam int MR_IDX_W      = 2;
    localparam int DLL_RESET_BIT = 8;

    localparam int GATE_MRD = 0;
    localparam int GATE_MOD = 1;
    localparam int GATE_PDE = 2;
    localparam int NUM_GATE = 3;

    typedef enum logic [2:0] {
        CODE_MRS = 3'b000,
        CODE_REF = 3'b001,
        CODE_PRE = 3'b010,
        CODE_ACT = 3'b011,
        CODE_WR  = 3'b100,
        CODE_RD  = 3'b101,
        CODE_ZQ  = 3'b110,
        CODE_NOP = 3'b111
    } cmd_code_e;

    function automatic logic [15:0] mr_default(input logic [MR_IDX_W-1:0] idx);
        case (idx)
            2'd0:    return 16'h0420;
            2'd1:    return 16'h0044;
            2'd2:    return 16'h0008;
            default: return 16'h0000;
        endcase
    endfunction

    // deselect or no-op may pass while the post-write window is open
    function automatic logic passes_window(input logic cs_n, input logic [2:0] code);
        return cs_n || (code == CODE_NOP);
    endfunction

    // counter load value per gate; the gap windows account for the output register
    function automatic int unsigned gate_load(input int g, input int unsigned mrd,
                                              input int unsigned mod, input int unsigned pde);
        case (g)
            GATE_MRD: return mrd - 2;
            GATE_MOD: return mod - 2;
            default:  return pde - 1;
        endcase
    endfunction

endpackage

// File: rtl/mrs_delay_ctr.sv
module mrs_delay_ctr #(
    parameter int unsigned LOAD_VAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = (LOAD_VAL < 2) ? 1 : $clog2(LOAD_VAL + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(LOAD_VAL);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mrs_shadow_bank.sv
module mrs_shadow_bank
    import mrs_seq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MR_IDX_W-1:0] sel,
    input  logic [ADDR_W-1:0]   mask,
    input  logic [ADDR_W-1:0]   data,
    input  logic                dll_clr,
    output logic [ADDR_W-1:0]   merged
);
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RESET_BIT;

    logic [ADDR_W-1:0] mr_rd [NUM_MR];

    for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
        logic [ADDR_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= ADDR_W'(mr_default(MR_IDX_W'(g)));
            else if (wr_en && (sel == MR_IDX_W'(g)))
                val_q <= merged;
            else if (dll_clr && (g == 0))
                val_q <= val_q & ~DLL_MASK;
        end
        assign mr_rd[g] = val_q;
    end

    assign merged = (mr_rd[sel] & ~mask) | (data & mask);
endmodule

// File: rtl/mrs_hold_slot.sv
module mrs_hold_slot
    import mrs_seq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MR_IDX_W-1:0] in_idx,
    input  logic [ADDR_W-1:0]   in_mask,
    input  logic [ADDR_W-1:0]   in_data,
    output logic                in_ready,
    input  logic                take,
    output logic                out_valid,
    output logic [MR_IDX_W-1:0] out_idx,
    output logic [ADDR_W-1:0]   out_mask,
    output logic [ADDR_W-1:0]   out_data
);
    typedef struct packed {
        logic                valid;
        logic [MR_IDX_W-1:0] idx;
        logic [ADDR_W-1:0]   mask;
        logic [ADDR_W-1:0]   data;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (in_valid && in_ready)
            slot_q <= '{valid: 1'b1, idx: in_idx, mask: in_mask, data: in_data};
        else if (take)
            slot_q.valid <= 1'b0;
    end

    assign in_ready  = !slot_q.valid;
    assign out_valid = slot_q.valid;
    assign out_idx   = slot_q.idx;
    assign out_mask  = slot_q.mask;
    assign out_data  = slot_q.data;
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
    import mrs_seq_pkg::*;
#(
    parameter int          ADDR_W = 14,
    parameter int          BANK_W = 3,
    parameter int unsigned T_MRD  = 4,
    parameter int unsigned T_MOD  = 12,
    parameter int unsigned T_PDE  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_idx,
    input  logic [ADDR_W-1:0]   req_mask,
    input  logic [ADDR_W-1:0]   req_data,
    output logic                req_ready,
    input  logic                oth_valid,
    input  logic                oth_cs_n,
    input  logic [2:0]          oth_cmd,
    input  logic [BANK_W-1:0]   oth_ba,
    input  logic [ADDR_W-1:0]   oth_addr,
    output logic                oth_ready,
    input  logic                banks_idle,
    input  logic                pd_req,
    input  logic                cmd_accept,
    output logic                cmd_valid,
    output logic                cmd_cs_n,
    output logic                cmd_ras_n,
    output logic                cmd_cas_n,
    output logic                cmd_we_n,
    output logic [BANK_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic                cke,
    output logic                ready
);
    typedef struct packed {
        logic              valid;
        logic              cs_n;
        logic [2:0]        code;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } bus_cmd_t;

    bus_cmd_t cmd_q;

    logic                p_valid;
    logic [MR_IDX_W-1:0] p_idx;
    logic [ADDR_W-1:0]   p_mask;
    logic [ADDR_W-1:0]   p_data;
    logic [ADDR_W-1:0]   merged;
    logic [NUM_GATE-1:0] busy;

    logic slot_free, cmd_is_mrs, mrs_fire, mrs_go, oth_go;

    assign slot_free  = !cmd_q.valid || cmd_accept;
    assign cmd_is_mrs = cmd_q.valid && !cmd_q.cs_n && (cmd_q.code == CODE_MRS);
    assign mrs_fire   = cmd_is_mrs && cmd_accept;
    assign mrs_go     = slot_free && p_valid && banks_idle && !busy[GATE_MRD] && !mrs_fire;
    assign oth_go     = slot_free && !mrs_go && oth_valid &&
                        (passes_window(oth_cs_n, oth_cmd) || (!busy[GATE_MOD] && !mrs_fire));

    mrs_hold_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_idx   (req_idx),
        .in_mask  (req_mask),
        .in_data  (req_data),
        .in_ready (req_ready),
        .take     (mrs_go),
        .out_valid(p_valid),
        .out_idx  (p_idx),
        .out_mask (p_mask),
        .out_data (p_data)
    );

    mrs_shadow_bank #(.ADDR_W(ADDR_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mrs_go),
        .sel    (p_idx),
        .mask   (p_mask),
        .data   (p_data),
        .dll_clr(mrs_fire && (cmd_q.ba[MR_IDX_W-1:0] == '0)),
        .merged (merged)
    );

    for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
        mrs_delay_ctr #(.LOAD_VAL(gate_load(g, T_MRD, T_MOD, T_PDE))) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .start(mrs_fire),
            .busy (busy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (mrs_go)
            cmd_q <= '{valid: 1'b1, cs_n: 1'b0, code: CODE_MRS,
                       ba: BANK_W'(p_idx), addr: merged};
        else if (oth_go)
            cmd_q <= '{valid: 1'b1, cs_n: oth_cs_n, code: oth_cmd,
                       ba: oth_ba, addr: oth_addr};
        else if (cmd_accept)
            cmd_q.valid <= 1'b0;
    end

    assign oth_ready = oth_go;
    assign cmd_valid = cmd_q.valid;
    assign cmd_cs_n  = cmd_q.cs_n;
    assign cmd_ras_n = cmd_q.code[2];
    assign cmd_cas_n = cmd_q.code[1];
    assign cmd_we_n  = cmd_q.code[0];
    assign cmd_ba    = cmd_q.ba;
    assign cmd_addr  = cmd_q.addr;
    assign cke       = !(pd_req && !busy[GATE_PDE] && !cmd_is_mrs);
    assign ready     = banks_idle && !(|busy);
endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk #(
    parameter int          ADDR_W = 14,
    parameter int          BANK_W = 3,
    parameter int unsigned T_MRD  = 4,
    parameter int unsigned T_MOD  = 12,
    parameter int unsigned T_PDE  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              banks_idle,
    input logic              cmd_accept,
    input logic              cmd_valid,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [BANK_W-1:0] cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cke
);
    logic        mrs_on_bus, mrs_take, ord_take;
    logic [15:0] since_q;

    assign mrs_on_bus = cmd_valid && !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
    assign mrs_take   = mrs_on_bus && cmd_accept;
    assign ord_take   = cmd_valid && cmd_accept && !cmd_cs_n && !mrs_on_bus &&
                        !(cmd_ras_n && cmd_cas_n && cmd_we_n);

    // cycles since the last accepted mode write, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= 16'hFFFF;
        else if (mrs_take)
            since_q <= 16'd1;
        else if (since_q != 16'hFFFF)
            since_q <= since_q + 16'd1;
    end

    assert_bank_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrs_on_bus) |-> $past(banks_idle));

    assert_mrd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_take |-> (since_q >= 16'(T_MRD)));

    assert_mod_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ord_take |-> (since_q >= 16'(T_MOD)));

    assert_cke_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!mrs_on_bus && since_q >= 16'(T_PDE)));

    assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_ba) &&
                                        $stable({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n})));

    assert_slot_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind mrs_seq mrs_seq_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_PDE(T_PDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .banks_idle(banks_idle),
    .cmd_accept(cmd_accept),
    .cmd_valid (cmd_valid),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_ba    (cmd_ba),
    .cmd_addr  (cmd_addr),
    .cke       (cke)
);

// File: tb/mrs_seq_tb.sv
module mrs_seq_tb;
    localparam int AW = 14, BW = 3;
    localparam int TMRD = 4, TMOD = 12, TPDE = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0; logic [1:0] req_idx = 0;
    logic [AW-1:0] req_mask = 0, req_data = 0;
    logic req_ready;
    logic oth_valid = 0, oth_cs_n = 0; logic [2:0] oth_cmd = 3'b111;
    logic [BW-1:0] oth_ba = 0; logic [AW-1:0] oth_addr = 0;
    logic oth_ready;
    logic banks_idle = 1, pd_req = 0, cmd_accept = 1;
    logic cmd_valid, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [BW-1:0] cmd_ba; logic [AW-1:0] cmd_addr;
    logic cke, ready;

    always #5 clk = ~clk;

    mrs_seq #(.ADDR_W(AW), .BANK_W(BW), .T_MRD(TMRD), .T_MOD(TMOD), .T_PDE(TPDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .req_mask(req_mask), .req_data(req_data), .req_ready(req_ready),
        .oth_valid(oth_valid), .oth_cs_n(oth_cs_n), .oth_cmd(oth_cmd), .oth_ba(oth_ba),
        .oth_addr(oth_addr), .oth_ready(oth_ready), .banks_idle(banks_idle), .pd_req(pd_req),
        .cmd_accept(cmd_accept), .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n),
        .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .cke(cke), .ready(ready));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // reference model
    logic [AW-1:0] sh [4];
    logic [AW-1:0] exp_addr [64];
    int            exp_idx  [64];
    int n_exp = 0;

    function automatic logic [AW-1:0] dflt(input int i);
        case (i) 0: return AW'(16'h0420); 1: return AW'(16'h0044);
                 2: return AW'(16'h0008); default: return '0; endcase
    endfunction

    // monitor of accepted commands
    int n_mrs = 0, n_oth = 0, last_mrs_cyc = -1000, last_oth_cyc = 0, mrs_gap = 0;
    logic [AW-1:0] last_mrs_addr; logic [2:0] last_oth_code; logic last_oth_cs;
    int kinds [64]; int n_kind = 0;

    always @(negedge clk) begin
        #1;
        if (rst_n && cmd_valid && cmd_accept) begin
            if (!cmd_cs_n && {cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b000) begin
                if (n_mrs < n_exp) begin
                    check(cmd_addr == exp_addr[n_mrs], "R6 addr", cmd_addr, exp_addr[n_mrs]);
                    check(cmd_ba == BW'(exp_idx[n_mrs]), "R6 ba", cmd_ba, exp_idx[n_mrs]);
                end else
                    check(0, "R2 unexpected mode write", n_mrs, n_exp);
                if (n_mrs > 0)
                    check(cyc - last_mrs_cyc >= TMRD, "R3 min gap", cyc - last_mrs_cyc, TMRD);
                mrs_gap = cyc - last_mrs_cyc;
                last_mrs_cyc = cyc; last_mrs_addr = cmd_addr;
                kinds[n_kind % 64] = 0;
                n_mrs++;
            end else begin
                last_oth_cyc = cyc; last_oth_code = {cmd_ras_n, cmd_cas_n, cmd_we_n};
                last_oth_cs = cmd_cs_n;
                kinds[n_kind % 64] = 1;
                n_oth++;
            end
            n_kind++;
        end
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 4; i++) sh[i] = dflt(i);
    endtask

    task automatic send_mr(input int idx, input logic [AW-1:0] mask, input logic [AW-1:0] data);
        logic [AW-1:0] m;
        m = (sh[idx] & ~mask) | (data & mask);
        exp_addr[n_exp] = m; exp_idx[n_exp] = idx; n_exp++;
        sh[idx] = (idx == 0) ? (m & ~(AW'(1) << 8)) : m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_idx = 2'(idx); req_mask = mask; req_data = data;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic push_oth(input logic cs, input logic [2:0] code);
        oth_valid = 1; oth_cs_n = cs; oth_cmd = code; oth_ba = 3'd5; oth_addr = AW'(14'h1234);
        #1;
        while (!oth_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        oth_valid = 0;
    endtask

    task automatic idle_wait();
        @(negedge clk);
        while (!(ready && !cmd_valid && req_ready)) @(negedge clk);
    endtask

    initial begin
        int t, k, base;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        check(cke == 1, "R1 cke", cke, 1);
        check(req_ready == 1, "R1 req_ready", req_ready, 1);
        check(ready == 1, "R9 ready after reset", ready, 1);

        // R1/R6 defaults with zero mask, then a merge sweep
        for (int i = 0; i < 4; i++) send_mr(i, '0, '1);
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 4; i++)
                send_mr(i, AW'((p * 5 + i * 3 + 1) * 1237), AW'((p * 7 + i + 2) * 2749));
        wait (n_mrs == n_exp);

        // R3 exact gap with the second write waiting
        idle_wait();
        send_mr(2, AW'(3), AW'(1));
        send_mr(3, AW'(12), AW'(4));
        wait (n_mrs == n_exp);
        check(mrs_gap == TMRD, "R3 exact gap", mrs_gap, TMRD);

        // R7 self-clearing bit of register 0
        idle_wait();
        send_mr(0, AW'(1) << 8, AW'(1) << 8);
        wait (n_mrs == n_exp);
        check(last_mrs_addr[8] == 1'b1, "R7 bit sent", last_mrs_addr[8], 1);
        send_mr(0, '0, '0);
        wait (n_mrs == n_exp);
        check(last_mrs_addr[8] == 1'b0, "R7 bit cleared", last_mrs_addr[8], 0);

        // R2 bank-idle gating and R11 slot occupancy
        idle_wait();
        banks_idle = 0;
        t = n_mrs;
        send_mr(1, AW'(1), AW'(0));
        repeat (20) @(negedge clk);
        check(n_mrs == t, "R2 held while busy", n_mrs, t);
        check(req_ready == 0, "R11 slot full", req_ready, 0);
        check(ready == 0, "R9 ready low while banks busy", ready, 0);
        banks_idle = 1; base = cyc;
        wait (n_mrs == t + 1);
        check(last_mrs_cyc - base == 1, "R2 release latency", last_mrs_cyc - base, 1);

        // R4 ordinary command waits exactly T_MOD
        idle_wait();
        t = n_mrs;
        send_mr(2, '0, '0);
        wait (n_mrs == t + 1);
        t = n_oth;
        push_oth(1'b0, 3'b011);
        wait (n_oth == t + 1);
        check(last_oth_cyc - last_mrs_cyc == TMOD, "R4 gap", last_oth_cyc - last_mrs_cyc, TMOD);
        check(last_oth_code == 3'b011, "R4 code", last_oth_code, 3'b011);

        // R5 no-op and deselect pass at once
        idle_wait();
        t = n_mrs;
        send_mr(3, '0, '0);
        wait (n_mrs == t + 1);
        t = n_oth;
        push_oth(1'b0, 3'b111);
        wait (n_oth == t + 1);
        check(last_oth_cyc - last_mrs_cyc == 1, "R5 no-op gap", last_oth_cyc - last_mrs_cyc, 1);
        idle_wait();
        t = n_mrs;
        send_mr(1, '0, '0);
        wait (n_mrs == t + 1);
        t = n_oth;
        push_oth(1'b1, 3'b011);
        wait (n_oth == t + 1);
        check(last_oth_cyc - last_mrs_cyc == 1, "R5 deselect gap", last_oth_cyc - last_mrs_cyc, 1);
        check(last_oth_cs == 1'b1, "R5 deselect cs", last_oth_cs, 1);

        // R8 cke window and R9 ready timing
        idle_wait();
        t = n_mrs;
        send_mr(2, '0, '0);
        wait (n_mrs == t + 1);
        pd_req = 1;
        for (k = 0; k <= TPDE; k++) begin
            if (k > 0) @(negedge clk);
            check(cke == !(k >= TPDE), "R8 cke", cke, !(k >= TPDE));
            if (k > 0)
                check(ready == (k >= TMRD - 1 && k >= TMOD - 1 && k >= TPDE),
                      "R9 ready", ready, (k >= TMRD - 1 && k >= TMOD - 1 && k >= TPDE));
        end
        pd_req = 0;
        @(negedge clk);
        check(cke == 1, "R8 cke after pd drop", cke, 1);

        // R10 hold under back-pressure
        idle_wait();
        cmd_accept = 0;
        t = n_mrs;
        send_mr(1, AW'(14'h0F00), AW'(14'h0A00));
        while (!cmd_valid) @(negedge clk);
        base = int'(cmd_addr);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check(cmd_valid && int'(cmd_addr) == base, "R10 hold", cmd_addr, base);
        end
        cmd_accept = 1;
        wait (n_mrs == t + 1);

        // R11 mode write wins over a waiting ordinary command
        idle_wait();
        cmd_accept = 0;
        push_oth(1'b0, 3'b111);
        send_mr(0, AW'(2), AW'(2));
        @(negedge clk);
        check(req_ready == 0, "R11 slot full", req_ready, 0);
        t = n_kind;
        oth_valid = 1; oth_cs_n = 0; oth_cmd = 3'b011;
        cmd_accept = 1;
        #1;
        while (!oth_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        oth_valid = 0;
        wait (n_kind == t + 3);
        check(kinds[t % 64] == 1 && kinds[(t + 1) % 64] == 0 && kinds[(t + 2) % 64] == 1,
              "R11 order", {kinds[t % 64][1:0], kinds[(t + 1) % 64][1:0], kinds[(t + 2) % 64][1:0]},
              6'b010001);

        // R12 reset restores defaults
        idle_wait();
        do_reset();
        @(negedge clk);
        check(cke == 1 && !cmd_valid, "R1 post reset outputs", {cke, cmd_valid}, 2'b10);
        for (int i = 0; i < 4; i++) send_mr(i, '0, '0);
        wait (n_mrs == n_exp);
        check(last_mrs_addr == dflt(3), "R12 default restored", last_mrs_addr, dflt(3));

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule